// File: doc/BRIEF.md
# Call and Return Stack Sequencer

This block handles subroutine entry and exit for a small processor with 8-bit data and a 16-bit program address. On a call it works out the return address from the address of the calling instruction and the call's length. It then stores that address, one byte at a time, on a byte-wide stack held inside the block, and loads the new program counter. On a return it reads the two bytes back, high byte first, and rebuilds the program counter.

Two call kinds exist. A long call jumps anywhere in the 64 KiB space. An absolute call replaces only the low 11 address bits. It keeps the 2 KiB page of the return address, so a call in the last two bytes of a page lands in the next page. The stack pointer is an 8-bit register that starts at 07h and wraps silently. While the block works through a sequence it holds `busy`, and it then pulses `done`. New requests are accepted only while the block is idle.

Top module: `call_ret_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block goes to: `sp_out` = 07h, `pc_out` = 0000h, `busy` = 0, `done` = 0, `stk_we` = 0.
- R2: Before each stack byte is written, the stack pointer goes up by one. The byte is written at the incremented value (`stk_addr` equals the `sp_out` that holds after the write), and each call raises `sp_out` by exactly 2.
- R3: A call writes the low byte of its return address first and the high byte in the next cycle, at the next address. The first call after reset therefore writes locations 08h and then 09h.
- R4: A long call (`call_long` = 1) pushes `call_pc` + 3 (modulo 2^16) and loads `pc_out` with `call_tgt` in full.
- R5: An absolute call (`call_long` = 0) pushes `call_pc` + 2. It loads `pc_out` with bits 15..11 of that return address joined to `call_tgt[10:0]`, and ignores `call_tgt[15:11]`.
- R6: A return reads the byte at `sp_out` into `pc_out[15:8]`, decrements, reads the byte at the new `sp_out` into `pc_out[7:0]`, and decrements again. The net effect restores the most recently pushed return address and lowers `sp_out` by 2.
- R7: A request is taken at a clock edge where the block is idle. `busy` is high for the next two cycles and low in the third. In that third cycle `done` is high for exactly one cycle, with `pc_out` and `sp_out` at their final values. `stk_we` is high only in the two busy cycles of a call.
- R8: Requests presented while `busy` is high have no effect. When `call_req` and `ret_req` are both high at an idle edge, the call is performed and the return is dropped.
- R9: The stack pointer wraps modulo 256. A push with `sp_out` = FFh writes location 00h, and nested calls keep working across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| call_req | input | 1 | Request a subroutine call |
| call_long | input | 1 | 1 = long call, 0 = absolute (in-page) call |
| call_pc | input | 16 | Address of the calling instruction |
| call_tgt | input | 16 | Target field: full address (long) or low 11 bits used (absolute) |
| ret_req | input | 1 | Request a return |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the sequence has finished |
| pc_out | output | 16 | Program counter |
| sp_out | output | 8 | Stack pointer |
| stk_we | output | 1 | Stack RAM write strobe |
| stk_addr | output | 8 | Stack RAM write address |
| stk_wdata | output | 8 | Stack RAM write byte |

## Verification
Some properties hold on every cycle, and the assertions check those. The stack pointer lands on the address just written. Back-to-back writes go to consecutive locations. A write happens only while busy. `done` is a single pulse that comes as `busy` falls, and the program counter does not move outside a sequence. Other behaviour needs the bench's scenarios: the return-address arithmetic, the page splice of absolute calls (including page-crossing return addresses), the byte order on the stack, the round trip through deeply nested calls that wrap the 8-bit pointer, call-over-return priority, and requests dropped while busy.

// File: rtl/crs_pkg.sv
`timescale 1ns/1ps
// crs_pkg: shared types for the call/return sequencer.
// Assumes nothing beyond a two-state program address split into two bytes.
package crs_pkg;

    // Sequencer phases: one push or pop per cycle.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PUSH_LO = 3'd1,
        ST_PUSH_HI = 3'd2,
        ST_POP_HI  = 3'd3,
        ST_POP_LO  = 3'd4
    } crs_state_e;

endpackage

// File: rtl/crs_addr_calc.sv
`timescale 1ns/1ps
// crs_addr_calc: combinational return-address and destination computation.
// Return address = calling address + instruction length (long or absolute).
// Absolute destinations keep the page bits of the return address.
// Assumes PAGE_W < ADDR_W.
module crs_addr_calc #(
    parameter int ADDR_W   = 16,
    parameter int PAGE_W   = 11,
    parameter int LONG_LEN = 3,
    parameter int ABS_LEN  = 2
) (
    input  logic              is_long,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] tgt_field,
    output logic [ADDR_W-1:0] ret_addr,
    output logic [ADDR_W-1:0] dest_addr
);
    localparam logic [ADDR_W-1:0] LONG_INC = ADDR_W'(LONG_LEN);
    localparam logic [ADDR_W-1:0] ABS_INC  = ADDR_W'(ABS_LEN);

    // Return address: skip past the call instruction.
    always_comb begin
        ret_addr = cur_addr + (is_long ? LONG_INC : ABS_INC);
    end

    // Destination: full field, or page of return address spliced with offset.
    always_comb begin
        if (is_long) begin
            dest_addr = tgt_field;
        end else begin
            dest_addr = {ret_addr[ADDR_W-1:PAGE_W], tgt_field[PAGE_W-1:0]};
        end
    end
endmodule

// File: rtl/crs_stack_ptr.sv
`timescale 1ns/1ps
// crs_stack_ptr: stack pointer register with increment and decrement.
// Wraps modulo 2**PTR_W without any error indication.
// Assumes inc and dec are never both high (increment wins if they are).
module crs_stack_ptr #(
    parameter int                PTR_W     = 8,
    parameter logic [PTR_W-1:0]  RESET_VAL = 8'h07
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [PTR_W-1:0] sp,
    output logic [PTR_W-1:0] sp_plus1
);
    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    logic [PTR_W-1:0] sp_q;

    // Pointer update: step up for a push, down for a pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= RESET_VAL;
        end else if (inc) begin
            sp_q <= sp_q + ONE;
        end else if (dec) begin
            sp_q <= sp_q - ONE;
        end
    end

    // Next location, used as the pre-incremented write address.
    always_comb begin
        sp       = sp_q;
        sp_plus1 = sp_q + ONE;
    end
endmodule

// File: rtl/crs_stack_ram.sv
`timescale 1ns/1ps
// crs_stack_ram: byte-wide stack storage, one write port, one async read port.
// Contents are not reset; only locations that have been written are read back.
module crs_stack_ram #(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << PTR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store one byte per cycle when enabled.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Combinational read of the current top of stack.
    always_comb begin
        rdata = mem[raddr];
    end
endmodule

// File: rtl/crs_ctrl.sv
`timescale 1ns/1ps
// crs_ctrl: sequencer for call (two pushes) and return (two pops).
// Owns the program counter and the busy/done handshake.
// Assumes ADDR_W == 2*DATA_W; requests are sampled only while idle, and a
// call has priority over a return at the same edge.
module crs_ctrl
    import crs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_req,
    input  logic              ret_req,
    input  logic [ADDR_W-1:0] ret_addr,
    input  logic [ADDR_W-1:0] dest_addr,
    input  logic [DATA_W-1:0] rd_byte,
    output logic              sp_inc,
    output logic              sp_dec,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_byte,
    output logic [ADDR_W-1:0] pc,
    output logic              busy,
    output logic              done
);
    localparam int HI_LSB = ADDR_W - DATA_W;

    crs_state_e        state_q;
    logic [ADDR_W-1:0] ret_q;
    logic [ADDR_W-1:0] dest_q;
    logic [ADDR_W-1:0] pc_q;
    logic              done_q;
    logic              idle;

    // Idle decode shared by the acceptance logic and the handshake.
    always_comb begin
        idle = (state_q == ST_IDLE);
    end

    // Phase sequencing, program counter loading and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ret_q   <= '0;
            dest_q  <= '0;
            pc_q    <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (call_req) begin
                        ret_q   <= ret_addr;
                        dest_q  <= dest_addr;
                        state_q <= ST_PUSH_LO;
                    end else if (ret_req) begin
                        state_q <= ST_POP_HI;
                    end
                end
                ST_PUSH_LO: begin
                    state_q <= ST_PUSH_HI;
                end
                ST_PUSH_HI: begin
                    pc_q    <= dest_q;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                ST_POP_HI: begin
                    pc_q[ADDR_W-1:HI_LSB] <= rd_byte;
                    state_q               <= ST_POP_LO;
                end
                ST_POP_LO: begin
                    pc_q[DATA_W-1:0] <= rd_byte;
                    done_q           <= 1'b1;
                    state_q          <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Stack strobes and the byte to push in each phase.
    always_comb begin
        sp_inc  = (state_q == ST_PUSH_LO) || (state_q == ST_PUSH_HI);
        sp_dec  = (state_q == ST_POP_HI)  || (state_q == ST_POP_LO);
        wr_en   = sp_inc;
        wr_byte = (state_q == ST_PUSH_LO) ? ret_q[DATA_W-1:0]
                                          : ret_q[ADDR_W-1:HI_LSB];
    end

    // Handshake and program counter outputs.
    always_comb begin
        busy = !idle;
        done = done_q;
        pc   = pc_q;
    end

    // The completion pulse lasts exactly one cycle.
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // A completion pulse is only seen after a sequence phase.
    assert_done_after_work_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $past(!idle));

    // Stack writes never happen while idle.
    assert_write_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !idle);
endmodule

// File: rtl/call_ret_seq.sv
`timescale 1ns/1ps
// call_ret_seq: subroutine call/return sequencer with an internal byte stack.
// A call pushes its return address (low byte, then high byte, each at a
// pre-incremented stack pointer) and loads the new program counter; a return
// pops high then low byte. Assumes a 16-bit address built from two bytes.
module call_ret_seq #(
    parameter int               ADDR_W   = 16,
    parameter int               DATA_W   = 8,
    parameter int               PTR_W    = 8,
    parameter int               PAGE_W   = 11,
    parameter int               LONG_LEN = 3,
    parameter int               ABS_LEN  = 2,
    parameter logic [PTR_W-1:0] SP_RESET = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_req,
    input  logic              call_long,
    input  logic [ADDR_W-1:0] call_pc,
    input  logic [ADDR_W-1:0] call_tgt,
    input  logic              ret_req,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] pc_out,
    output logic [PTR_W-1:0]  sp_out,
    output logic              stk_we,
    output logic [PTR_W-1:0]  stk_addr,
    output logic [DATA_W-1:0] stk_wdata
);
    logic [ADDR_W-1:0] ret_addr;
    logic [ADDR_W-1:0] dest_addr;
    logic [DATA_W-1:0] rd_byte;
    logic [PTR_W-1:0]  sp_cur;
    logic [PTR_W-1:0]  sp_next;
    logic              sp_inc;
    logic              sp_dec;
    logic              wr_en;
    logic [DATA_W-1:0] wr_byte;

    crs_addr_calc #(
        .ADDR_W  (ADDR_W),
        .PAGE_W  (PAGE_W),
        .LONG_LEN(LONG_LEN),
        .ABS_LEN (ABS_LEN)
    ) addr_i (
        .is_long  (call_long),
        .cur_addr (call_pc),
        .tgt_field(call_tgt),
        .ret_addr (ret_addr),
        .dest_addr(dest_addr)
    );

    crs_stack_ptr #(
        .PTR_W    (PTR_W),
        .RESET_VAL(SP_RESET)
    ) sp_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (sp_inc),
        .dec     (sp_dec),
        .sp      (sp_cur),
        .sp_plus1(sp_next)
    );

    crs_stack_ram #(
        .DATA_W(DATA_W),
        .PTR_W (PTR_W)
    ) ram_i (
        .clk  (clk),
        .we   (wr_en),
        .waddr(sp_next),
        .wdata(wr_byte),
        .raddr(sp_cur),
        .rdata(rd_byte)
    );

    crs_ctrl #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .call_req (call_req),
        .ret_req  (ret_req),
        .ret_addr (ret_addr),
        .dest_addr(dest_addr),
        .rd_byte  (rd_byte),
        .sp_inc   (sp_inc),
        .sp_dec   (sp_dec),
        .wr_en    (wr_en),
        .wr_byte  (wr_byte),
        .pc       (pc_out),
        .busy     (busy),
        .done     (done)
    );

    // Expose the stack pointer and the write side of the stack storage.
    always_comb begin
        sp_out    = sp_cur;
        stk_we    = wr_en;
        stk_addr  = sp_next;
        stk_wdata = wr_byte;
    end

    // After a write, the pointer rests on the location just written.
    assert_sp_on_written_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stk_we |=> (sp_out == $past(stk_addr)));

    // Back-to-back writes of one call go to consecutive locations.
    assert_push_consecutive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_we && $past(stk_we)) |-> (stk_addr == $past(stk_addr) + PTR_W'(1)));

    // The completion pulse comes exactly as busy falls.
    assert_done_at_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // Outside a sequence and its completion cycle the program counter holds.
    assert_pc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && $past(!busy)) |-> $stable(pc_out));
endmodule

// File: tb/call_ret_seq_tb_top.sv
`timescale 1ns/1ps
// Bench: directed corner calls plus a deep nested sweep across pointer wrap.
module call_ret_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        call_req;
    logic        call_long;
    logic [15:0] call_pc;
    logic [15:0] call_tgt;
    logic        ret_req;
    logic        busy;
    logic        done;
    logic [15:0] pc_out;
    logic [7:0]  sp_out;
    logic        stk_we;
    logic [7:0]  stk_addr;
    logic [7:0]  stk_wdata;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [7:0]  m_sp;
    logic [7:0]  m_mem [256];
    logic [15:0] rstk [300];
    int          depth = 0;

    always #10 clk = ~clk;

    call_ret_seq dut_i (
        .clk(clk), .rst_n(rst_n), .call_req(call_req), .call_long(call_long),
        .call_pc(call_pc), .call_tgt(call_tgt), .ret_req(ret_req),
        .busy(busy), .done(done), .pc_out(pc_out), .sp_out(sp_out),
        .stk_we(stk_we), .stk_addr(stk_addr), .stk_wdata(stk_wdata)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Call with optional simultaneous return (priority) and noise while busy.
    task automatic do_call(input logic lng, input logic [15:0] ia,
                           input logic [15:0] tg, input logic both, input logic noise);
        logic [15:0] ra;
        logic [15:0] np;
        ra = ia + (lng ? 16'd3 : 16'd2);
        np = lng ? tg : {ra[15:11], tg[10:0]};
        call_req = 1'b1; call_long = lng; call_pc = ia; call_tgt = tg; ret_req = both;
        @(negedge clk);
        call_req = noise; ret_req = noise; call_pc = ~ia; call_tgt = ~tg;
        m_sp = m_sp + 8'd1;
        check(busy === 1'b1, "R7 busy1", int'(busy), 1);
        check(stk_we === 1'b1 && stk_addr === m_sp, "R2 lo addr", int'(stk_addr), int'(m_sp));
        check(stk_wdata === ra[7:0], "R3 lo byte", int'(stk_wdata), int'(ra[7:0]));
        m_mem[m_sp] = ra[7:0];
        @(negedge clk);
        m_sp = m_sp + 8'd1;
        check(busy === 1'b1 && done === 1'b0, "R7 busy2", int'(busy), 1);
        check(stk_we === 1'b1 && stk_addr === m_sp, "R3 hi addr", int'(stk_addr), int'(m_sp));
        check(stk_wdata === ra[15:8], "R3 hi byte", int'(stk_wdata), int'(ra[15:8]));
        m_mem[m_sp] = ra[15:8];
        @(negedge clk);
        call_req = 1'b0; ret_req = 1'b0;
        check(busy === 1'b0 && done === 1'b1 && stk_we === 1'b0, "R7 done", int'(done), 1);
        check(pc_out === np, lng ? "R4 pc" : "R5 pc", int'(pc_out), int'(np));
        check(sp_out === m_sp, "R2 sp", int'(sp_out), int'(m_sp));
        @(negedge clk);
        check(done === 1'b0 && busy === 1'b0, "R8 idle after", int'(busy), 0);
        check(sp_out === m_sp && pc_out === np, "R8 no extra op", int'(sp_out), int'(m_sp));
        rstk[depth] = ra;
        depth++;
    endtask

    // Return, restoring the newest pushed address.
    task automatic do_ret(input logic noise);
        logic [15:0] ex;
        depth--;
        ex = rstk[depth];
        ret_req = 1'b1;
        @(negedge clk);
        ret_req = noise; call_req = noise; call_long = 1'b1; call_tgt = 16'h5A5A;
        check(busy === 1'b1 && stk_we === 1'b0, "R7 pop busy", int'(busy), 1);
        check(sp_out === m_sp, "R6 sp before pop", int'(sp_out), int'(m_sp));
        @(negedge clk);
        check(busy === 1'b1, "R7 pop busy2", int'(busy), 1);
        check(pc_out[15:8] === m_mem[m_sp], "R6 hi first", int'(pc_out[15:8]), int'(m_mem[m_sp]));
        @(negedge clk);
        ret_req = 1'b0; call_req = 1'b0;
        m_sp = m_sp - 8'd2;
        check(done === 1'b1 && busy === 1'b0, "R7 pop done", int'(done), 1);
        check(pc_out === ex, "R6 pc", int'(pc_out), int'(ex));
        check(sp_out === m_sp, "R6 sp", int'(sp_out), int'(m_sp));
        @(negedge clk);
        check(done === 1'b0 && busy === 1'b0 && sp_out === m_sp, "R8 idle after pop",
              int'(sp_out), int'(m_sp));
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; call_req = 1'b0; ret_req = 1'b0; call_long = 1'b0;
        call_pc = '0; call_tgt = '0;
        repeat (4) @(negedge clk);
        // R1: reset values
        check(sp_out === 8'h07, "R1 sp", int'(sp_out), 7);
        check(pc_out === 16'h0000, "R1 pc", int'(pc_out), 0);
        check(busy === 1'b0 && done === 1'b0 && stk_we === 1'b0, "R1 idle", int'(busy), 0);
        rst_n = 1'b1;
        m_sp = 8'h07;
        @(negedge clk);

        // R3/R4: first long call lands at 08h/09h
        do_call(1'b1, 16'h3254, 16'h1234, 1'b0, 1'b0);
        check(m_sp === 8'h09, "R3 first pair", int'(m_sp), 9);
        do_ret(1'b0);
        // R5: absolute call, page bits from return address
        do_call(1'b0, 16'h8549, 16'hFABC, 1'b0, 1'b0);
        check(pc_out === 16'h82BC, "R5 splice", int'(pc_out), 16'h82BC);
        // R5: return address crosses into next page
        do_call(1'b0, 16'h07FE, 16'h0123, 1'b0, 1'b1);
        check(pc_out === 16'h0923, "R5 page cross", int'(pc_out), 16'h0923);
        // R4: return address wraps past FFFFh
        do_call(1'b1, 16'hFFFE, 16'hBEEF, 1'b0, 1'b0);
        // R8: call wins over simultaneous return
        do_call(1'b1, 16'h4000, 16'h0042, 1'b1, 1'b1);
        do_ret(1'b1);
        do_ret(1'b0);
        do_ret(1'b1);
        do_ret(1'b0);

        // R9: deep nesting wraps the 8-bit pointer
        for (int k = 0; k < 126; k++) begin
            do_call(k[0], 16'(k * 16'h0517 + 16'h07F0), 16'(k * 16'h1357), 1'b0, k[1]);
        end
        check(sp_out === 8'h03, "R9 wrapped sp", int'(sp_out), 3);
        for (int k = 0; k < 126; k++) begin
            do_ret(k[2]);
        end
        check(sp_out === 8'h07, "R9 sp restored", int'(sp_out), 7);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule